// File: doc/BRIEF.md
# GPIO output latch with atomic bit set and clear

This block keeps the output levels of a 16-pin general-purpose port and drives them onto a pin vector. Software reaches it through a simple register bus with an address, a write strobe with 32-bit data, a read strobe and combinational read data. Two registers are mapped.

The first is the output latch itself. It can be read, and a write to it replaces every implemented pin at once. The second is a write-only command register at offset 0x818. Its lower half raises the pins whose bits are written as one. Its upper half lowers pin n when bit n+16 is written as one. A single bus write can therefore change any mix of pins without a read-modify-write sequence, so no other bus master can slip in between.

When one write both raises and lowers the same pin, raising takes precedence. Only pins 0 to 6 and 13 to 15 exist. Every other pin position stays low, reads back as zero, and ignores both kinds of write.

Top module: `gpio_atomic_port`

## Requirements
- R1: While rst_n is low at a rising clock edge, the output latch is cleared, so pin_out is 0 after that edge and a read of the latch returns 0.
- R2: A write to offset 0x818 with a one in bit n (n in 15:0, implemented pin) drives pin n high after the clock edge; pins whose lower-half bit is zero and upper-half bit is zero keep their level.
- R3: A write to offset 0x818 with a one in bit n+16 and a zero in bit n drives implemented pin n low after the clock edge.
- R4: When one write to offset 0x818 has ones in both bit n and bit n+16, pin n ends high.
- R5: A read at offset 0x818 returns 0 regardless of the latch contents.
- R6: Pin positions 7 to 12 are not implemented: pin_out bits 7 to 12 are always 0, latch read bits 7 to 12 are 0, and command bits 12:7 and 28:23 have no effect on any pin.
- R7: A write to offset 0x814 loads wr_data[15:0], masked to the implemented pins, into the latch; wr_data[31:16] is ignored; a read at 0x814 returns {16'h0, latch}.
- R8: pin_out keeps its old value until the rising clock edge that accepts a write, changes on that edge, and always equals the latch read value.
- R9: A write to offset 0x818 with all 32 data bits zero leaves every pin unchanged.
- R10: A write strobe at any offset other than 0x814 and 0x818 leaves every pin unchanged.
- R11: rd_data is 0 whenever rd_en is low or the address matches neither mapped offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 12 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe, accepted on the rising edge |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Combinational read data |
| pin_out | output | 16 | Output levels of the port pins |

## Verification
The hardest case to reach from the ports is a pin that is raised and lowered by the same write. The clear half must be shown to lose even when the pin was low before the write, and also when the pin was already high. The stimulus first lowers pin 0 with a clear-only command. It then issues a combined command for pins 0 and 14 and compares the result against a model that applies the set half after the clear half. A command that fills only the reserved bit fields is checked through a readback of the latch, which shows that no hidden pin changed.

// File: rtl/gpio_atomic_pkg.sv
package gpio_atomic_pkg;

   // register selected by one bus access
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_LAT  = 2'd1,
      SEL_CMD  = 2'd2
   } gpio_sel_e;

   localparam int unsigned DEF_PINS   = 16;
   localparam int unsigned DEF_BUS_W  = 32;
   localparam int unsigned DEF_ADDR_W = 12;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
   import gpio_atomic_pkg::*;
#(
   parameter int unsigned          ADDR_W  = DEF_ADDR_W,
   parameter logic [ADDR_W-1:0]    LAT_OFS = 12'h814,
   parameter logic [ADDR_W-1:0]    CMD_OFS = 12'h818
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   output gpio_sel_e         wr_sel,
   output gpio_sel_e         rd_sel
);

   gpio_sel_e hit;

   always_comb begin
      if (addr == LAT_OFS)
         hit = SEL_LAT;
      else if (addr == CMD_OFS)
         hit = SEL_CMD;
      else
         hit = SEL_NONE;
      wr_sel = wr_en ? hit : SEL_NONE;
      rd_sel = rd_en ? hit : SEL_NONE;
   end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
   import gpio_atomic_pkg::*;
#(
   parameter int unsigned       PINS      = DEF_PINS,
   parameter int unsigned       BUS_W     = DEF_BUS_W,
   parameter logic [PINS-1:0]   IMPL_MASK = 16'hE07F,
   parameter bit                SET_WINS  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  gpio_sel_e        wr_sel,
   input  logic [BUS_W-1:0] wdata,
   output logic [PINS-1:0]  lat_q
);

   localparam int unsigned CLR_LO = PINS;
   localparam int unsigned CLR_HI = 2 * PINS - 1;

   logic [PINS-1:0] raise_v;
   logic [PINS-1:0] lower_v;
   logic [PINS-1:0] cmd_nxt;
   logic [PINS-1:0] lat_nxt;

   assign raise_v = wdata[PINS-1:0];
   assign lower_v = wdata[CLR_HI:CLR_LO];

   // priority of the two command halves on a shared pin
   generate
      if (SET_WINS) begin : g_raise_first
         assign cmd_nxt = (lat_q & ~lower_v) | raise_v;
      end else begin : g_lower_first
         assign cmd_nxt = (lat_q | raise_v) & ~lower_v;
      end
   endgenerate

   always_comb begin
      unique case (wr_sel)
         SEL_LAT: lat_nxt = raise_v;
         SEL_CMD: lat_nxt = cmd_nxt;
         default: lat_nxt = lat_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         lat_q <= '0;
      else
         lat_q <= lat_nxt & IMPL_MASK;
   end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
   import gpio_atomic_pkg::*;
#(
   parameter int unsigned PINS  = DEF_PINS,
   parameter int unsigned BUS_W = DEF_BUS_W
) (
   input  gpio_sel_e        rd_sel,
   input  logic [PINS-1:0]  lat_q,
   output logic [BUS_W-1:0] rd_data
);

   localparam int unsigned PAD_W = BUS_W - PINS;

   // command register is write-only and reads as zero
   always_comb begin
      if (rd_sel == SEL_LAT)
         rd_data = {{PAD_W{1'b0}}, lat_q};
      else
         rd_data = '0;
   end

endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
   import gpio_atomic_pkg::*;
#(
   parameter int unsigned          PINS      = DEF_PINS,
   parameter int unsigned          BUS_W     = DEF_BUS_W,
   parameter int unsigned          ADDR_W    = DEF_ADDR_W,
   parameter logic [PINS-1:0]      IMPL_MASK = 16'hE07F,
   parameter logic [ADDR_W-1:0]    LAT_OFS   = 12'h814,
   parameter logic [ADDR_W-1:0]    CMD_OFS   = 12'h818,
   parameter bit                   SET_WINS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic              rd_en,
   output logic [BUS_W-1:0]  rd_data,
   output logic [PINS-1:0]   pin_out
);

   // elaboration-time parameter checks
   generate
      if (BUS_W != 2 * PINS) begin : g_bad_bus
         $error("bus width must hold a raise half and a lower half");
      end
      if (LAT_OFS == CMD_OFS) begin : g_bad_map
         $error("latch and command offsets must differ");
      end
      if (IMPL_MASK == '0) begin : g_bad_mask
         $error("at least one pin must be implemented");
      end
   endgenerate

   gpio_sel_e       wr_sel;
   gpio_sel_e       rd_sel;
   logic [PINS-1:0] lat_q;

   gpio_reg_decode #(
      .ADDR_W (ADDR_W),
      .LAT_OFS(LAT_OFS),
      .CMD_OFS(CMD_OFS)
   ) u_dec (
      .addr  (addr),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .wr_sel(wr_sel),
      .rd_sel(rd_sel)
   );

   gpio_out_latch #(
      .PINS     (PINS),
      .BUS_W    (BUS_W),
      .IMPL_MASK(IMPL_MASK),
      .SET_WINS (SET_WINS)
   ) u_lat (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_sel(wr_sel),
      .wdata (wr_data),
      .lat_q (lat_q)
   );

   gpio_read_mux #(
      .PINS (PINS),
      .BUS_W(BUS_W)
   ) u_rd (
      .rd_sel (rd_sel),
      .lat_q  (lat_q),
      .rd_data(rd_data)
   );

   assign pin_out = lat_q;

endmodule

// File: rtl/gpio_atomic_port_chk.sv
module gpio_atomic_port_chk #(
   parameter int unsigned       PINS      = 16,
   parameter int unsigned       BUS_W     = 32,
   parameter int unsigned       ADDR_W    = 12,
   parameter logic [PINS-1:0]   IMPL_MASK = 16'hE07F,
   parameter logic [ADDR_W-1:0] LAT_OFS   = 12'h814,
   parameter logic [ADDR_W-1:0] CMD_OFS   = 12'h818
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [BUS_W-1:0]  wr_data,
   input logic              rd_en,
   input logic [BUS_W-1:0]  rd_data,
   input logic [PINS-1:0]   pin_out
);

   logic cmd_wr;
   logic any_wr;
   assign cmd_wr = wr_en && (addr == CMD_OFS);
   assign any_wr = wr_en && ((addr == CMD_OFS) || (addr == LAT_OFS));

   // R1
   reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_out == '0));

   // R6
   hidden_pins_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~IMPL_MASK) == '0);

   // R2
   raise_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> ((pin_out & $past(wr_data[PINS-1:0]) & IMPL_MASK)
                  == ($past(wr_data[PINS-1:0]) & IMPL_MASK)));

   // R3
   lower_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> ((pin_out & $past(wr_data[2*PINS-1:PINS] & ~wr_data[PINS-1:0])) == '0));

   // R9
   empty_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && (wr_data == '0)) |=> $stable(pin_out));

   // R10
   no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_wr |=> $stable(pin_out));

   // R5
   cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr == CMD_OFS)) |-> (rd_data == '0));

   // R11
   idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rd_data == '0));

endmodule

bind gpio_atomic_port gpio_atomic_port_chk #(
   .PINS     (PINS),
   .BUS_W    (BUS_W),
   .ADDR_W   (ADDR_W),
   .IMPL_MASK(IMPL_MASK),
   .LAT_OFS  (LAT_OFS),
   .CMD_OFS  (CMD_OFS)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .addr   (addr),
   .wr_en  (wr_en),
   .wr_data(wr_data),
   .rd_en  (rd_en),
   .rd_data(rd_data),
   .pin_out(pin_out)
);

// File: tb/tb_gpio_atomic_port.sv
`timescale 1ns/1ps
module tb_gpio_atomic_port;

   localparam logic [15:0] MASK = 16'hE07F;
   localparam logic [11:0] LAT  = 12'h814;
   localparam logic [11:0] CMD  = 12'h818;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic [15:0] pin_out;

   int total = 0;
   int bad = 0;
   logic [15:0] exp_lat = '0;

   always #2 clk = ~clk;

   gpio_atomic_port dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .pin_out(pin_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] model_cmd(input logic [15:0] cur, input logic [31:0] d);
      return ((cur & ~d[31:16]) | d[15:0]) & MASK;
   endfunction

   task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      #1;
      chk("R8 before edge", {16'h0, pin_out}, {16'h0, exp_lat});
      if (a == CMD) exp_lat = model_cmd(exp_lat, d);
      else if (a == LAT) exp_lat = d[15:0] & MASK;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1;
      d = rd_data;
      rd_en = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] r;
      chk("R1 pins after reset", {16'h0, pin_out}, 32'h0);
      bus_rd(LAT, r);
      chk("R1 latch read after reset", r, 32'h0);
   endtask

   task automatic t_raise;
      bus_wr(CMD, 32'h0000_0005);
      chk("R2 raise 0 and 2", {16'h0, pin_out}, 32'h0005);
      bus_wr(CMD, 32'h0000_8040);
      chk("R2 raise keeps others", {16'h0, pin_out}, 32'h8045);
      chk("R8 pin equals model", {16'h0, pin_out}, {16'h0, exp_lat});
   endtask

   task automatic t_lower;
      bus_wr(CMD, 32'h0004_0000);
      chk("R3 lower pin 2", {16'h0, pin_out}, 32'h8041);
      bus_wr(CMD, 32'h0001_0000);
      chk("R3 lower pin 0", {16'h0, pin_out}, 32'h8040);
   endtask

   task automatic t_both;
      bus_wr(CMD, 32'h4001_4001);
      chk("R4 both on low pins", {16'h0, pin_out}, 32'hC041);
      bus_wr(CMD, 32'h0040_0040);
      chk("R4 both on high pin", {16'h0, pin_out}, 32'hC041);
   endtask

   task automatic t_reserved;
      logic [31:0] r;
      bus_wr(CMD, 32'h1F80_1F80);
      chk("R6 reserved command bits", {16'h0, pin_out}, 32'hC041);
      bus_wr(LAT, 32'h0000_FFFF);
      chk("R6 hidden pins stay low", {16'h0, pin_out}, 32'hE07F);
      bus_rd(LAT, r);
      chk("R6 hidden bits read zero", r, 32'h0000_E07F);
      bus_wr(CMD, 32'h1F80_0000);
      chk("R6 reserved clear bits ignored", {16'h0, pin_out}, 32'hE07F);
   endtask

   task automatic t_direct;
      logic [31:0] r;
      bus_wr(LAT, 32'h0000_A05A);
      chk("R7 direct load", {16'h0, pin_out}, 32'hA05A);
      bus_rd(LAT, r);
      chk("R7 direct readback", r, 32'h0000_A05A);
      bus_wr(LAT, 32'hFFFF_0000);
      chk("R7 upper half ignored", {16'h0, pin_out}, 32'h0000);
      bus_wr(LAT, 32'h0000_6021);
   endtask

   task automatic t_empty_and_decode;
      bus_wr(CMD, 32'h0000_0000);
      chk("R9 empty command", {16'h0, pin_out}, 32'h6021);
      bus_wr(12'h81C, 32'hFFFF_FFFF);
      chk("R10 unmapped write", {16'h0, pin_out}, 32'h6021);
      bus_wr(12'h014, 32'h0000_FFFF);
      chk("R10 aliased low bits", {16'h0, pin_out}, 32'h6021);
   endtask

   task automatic t_reads;
      logic [31:0] r;
      bus_rd(CMD, r);
      chk("R5 command reads zero", r, 32'h0);
      bus_rd(12'h000, r);
      chk("R11 unmapped read", r, 32'h0);
      @(negedge clk);
      addr = LAT; rd_en = 1'b0;
      #1;
      chk("R11 no read strobe", rd_data, 32'h0);
   endtask

   task automatic t_mid_reset;
      logic [31:0] r;
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      chk("R1 mid-run reset", {16'h0, pin_out}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      exp_lat = '0;
      bus_rd(LAT, r);
      chk("R1 latch after mid reset", r, 32'h0);
   endtask

   initial begin
      #800000;
      bad++;
      $display("FAIL watchdog all requirements act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      t_raise();
      t_lower();
      t_both();
      t_reserved();
      t_direct();
      t_empty_and_decode();
      t_reads();
      t_mid_reset();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule